// File: doc/BRIEF.md
# Power-Down Mode Clock Sequencer

This block decides, cycle by cycle, whether a processor core, its peripherals and its clock multiplier are allowed to run. The core announces that it has executed an idle instruction with a one-cycle strobe. Two mode bits from a control register then choose what happens. If neither bit is set, the clocks keep running. If only the stop-all bit is set, the core and peripheral clocks are gated and the multiplier keeps running. If the power-down bit is set, everything stops, the multiplier included. An interrupt ends any of these waits. Once the block is back in run mode it sends the core a one-cycle resume pulse, and the core continues with the instruction after the idle.

All timing runs on a free-running reference clock that is never gated, so the wake counters do not depend on the clocks they restore. The short wake takes a fixed number of cycles. The deep wake first restarts the multiplier and then waits for it to settle. After reset the block also waits for the multiplier to lock before it enables any clock. The peripheral clock enable pulses either on every core cycle or on every second core cycle, as a rate-select bit chooses.

Top module: `pwr_clk_seq`

## Requirements
- R1: While `rst_n` is low, and for LOCK_CYCLES (default 100) cycles counted from the first cycle with `rst_n` high, `core_clk_en`, `periph_clk_en`, `pbus_en`, `resume` and `ctx_lost` are low and `pll_run` is high. In cycle c+LOCK_CYCLES, where c is that first cycle, `core_clk_en` and `pbus_en` go high. No resume pulse follows reset.
- R2: An `idle_stb` in run mode with `mode_stopall`=1, `mode_deep`=0 and `irq`=0 enters the shallow mode. From the next cycle on, `core_clk_en`, `periph_clk_en` and `pbus_en` are low, `pll_run` is high and `ctx_lost` is low.
- R3: An `idle_stb` in run mode with `mode_deep`=1 and `irq`=0 enters the deep mode, whatever `mode_stopall` holds. From the next cycle on, `core_clk_en`, `periph_clk_en`, `pll_run` and `pbus_en` are low and `ctx_lost` is high.
- R4: If `irq` is high in cycle k while the block is in shallow mode, then the clocks, `pbus_en` and a one-cycle `resume` all appear in cycle k+SHORT_WAKE (default 6). Before that cycle the clocks stay gated.
- R5: If `irq` is high in cycle k while the block is in deep mode, then `pll_run` is high from cycle k+1. `ctx_lost` stays high and the clocks stay gated until cycle k+PLL_SETTLE (default 500). In that cycle the clocks, `pbus_en` and a one-cycle `resume` appear.
- R6: In run mode with `rate_half`=0, `periph_clk_en` is high on every cycle. With `rate_half`=1 it is high on the first run cycle after any wait and on every second cycle after that.
- R7: `idle_stb` has no effect outside run mode. An `irq` in run mode with no outstanding plain idle changes no output.
- R8: An `idle_stb` that arrives with `irq` already high leaves the block in run mode with its clocks on. It gives `resume` in the next cycle.
- R9: An `idle_stb` with both mode bits clear keeps every clock running. The next `irq`, high in cycle k, gives `resume` in cycle k+1.
- R10: Each exit from an idle gives exactly one `resume` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock, never gated |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_stopall | input | 1 | Control bit: gate core and peripheral clocks on idle |
| mode_deep | input | 1 | Control bit: also stop the clock multiplier on idle |
| rate_half | input | 1 | Peripheral clock at half the core rate when 1 |
| idle_stb | input | 1 | One-cycle strobe: idle instruction executed |
| irq | input | 1 | Interrupt request (level) |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable pulse |
| pll_run | output | 1 | Clock multiplier run enable |
| pbus_en | output | 1 | Peripheral bus accepts transfers |
| ctx_lost | output | 1 | Pipeline contents are not retained |
| resume | output | 1 | One-cycle pulse: continue after the idle |

## Verification
The bench targets the exact exit cycle of both wake paths. A counter that is off by one would move `resume` one cycle early or late relative to the interrupt. The bench also tests an interrupt that is already pending when the idle strobe arrives. A design that skips this check would fall asleep and wait for an interrupt that has already come. Idle strobes sent during a sleep must be ignored. A design that reacts to them would re-enter sleep or restart its counter, and a plain idle must not stop any clock. The bench also checks the half-rate peripheral phase after each wake. A divider that keeps its phase across a wait would start on the wrong cycle.

// File: rtl/pwr_seq_pkg.sv
// Shared state type for the power-down clock sequencer.
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_SHALLOW,
        ST_DEEP,
        ST_WAKE_SHORT,
        ST_WAKE_PLL,
        ST_RESET_LOCK
    } pwr_state_e;
endpackage

// File: rtl/pwr_wake_timer.sv
// Wake-up delay counter on the free-running reference clock.
// What it does: counts up while count_en is high and signals done when the
// count reaches target. clr restarts it from zero.
// What it assumes: target stays constant while one wait is in progress.
module pwr_wake_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             count_en,
    input  logic [CNT_W-1:0] target,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Count the elapsed cycles of the current wait.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (count_en) cnt <= cnt + 1'b1;
    end

    // Flag the last cycle of the wait.
    always_comb done = count_en && (cnt == target);

    // The count never passes its target during a wait (R5).
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |-> cnt <= target);
endmodule

// File: rtl/pwr_pclk_div.sv
// Peripheral clock enable generator.
// What it does: passes every core cycle, or every second core cycle when
// rate_half is set. The phase restarts on every return to run mode.
// What it assumes: run is high exactly when the core clock is enabled.
module pwr_pclk_div (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rate_half,
    output logic periph_en
);
    logic phase;

    // Alternate the phase while running and clear it when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)   phase <= 1'b0;
        else if (run) phase <= ~phase;
        else          phase <= 1'b0;
    end

    // Pulse on phase zero at half rate, on every cycle at full rate.
    always_comb periph_en = run && (!rate_half || !phase);

    // Two half-rate pulses never fall on consecutive cycles (R6).
    p_half_rate_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_half && $past(rate_half) && $past(periph_en)) |-> !periph_en);
endmodule

// File: rtl/pwr_mode_fsm.sv
// Sleep-mode state machine.
// What it does: picks the sleep depth when an idle strobe arrives, leaves
// the sleep on an interrupt, and times the wake and reset-lock waits
// through an external timer. It registers a single resume pulse.
// What it assumes: SHORT_WAKE >= 2, PLL_SETTLE >= 2 and LOCK_CYCLES >= 1.
// All three limits fit in CNT_W bits.
module pwr_mode_fsm
    import pwr_seq_pkg::*;
#(
    parameter int LOCK_CYCLES = 100,
    parameter int SHORT_WAKE  = 6,
    parameter int PLL_SETTLE  = 500,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_stb,
    input  logic             irq,
    input  logic             mode_stopall,
    input  logic             mode_deep,
    input  logic             tmr_done,
    output pwr_state_e       st,
    output logic             tmr_clr,
    output logic             tmr_en,
    output logic [CNT_W-1:0] tmr_target,
    output logic             resume
);
    localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(SHORT_WAKE - 2);
    localparam logic [CNT_W-1:0] T_PLL   = CNT_W'(PLL_SETTLE - 2);
    localparam logic [CNT_W-1:0] T_LOCK  = CNT_W'(LOCK_CYCLES - 1);

    pwr_state_e st_nx;
    logic       res_nx;
    logic       idle_wait;
    logic       wait_nx;

    // Next-state and resume decision.
    always_comb begin
        st_nx   = st;
        res_nx  = 1'b0;
        wait_nx = idle_wait;
        unique case (st)
            ST_RUN: begin
                if (idle_stb) begin
                    wait_nx = 1'b0;
                    if (irq)               res_nx  = 1'b1;
                    else if (mode_deep)    st_nx   = ST_DEEP;
                    else if (mode_stopall) st_nx   = ST_SHALLOW;
                    else                   wait_nx = 1'b1;
                end else if (idle_wait && irq) begin
                    res_nx  = 1'b1;
                    wait_nx = 1'b0;
                end
            end
            ST_SHALLOW:    if (irq) st_nx = ST_WAKE_SHORT;
            ST_DEEP:       if (irq) st_nx = ST_WAKE_PLL;
            ST_WAKE_SHORT,
            ST_WAKE_PLL: if (tmr_done) begin
                st_nx  = ST_RUN;
                res_nx = 1'b1;
            end
            ST_RESET_LOCK: if (tmr_done) st_nx = ST_RUN;
            default:       st_nx = ST_RESET_LOCK;
        endcase
    end

    // Timer control: count in the wait states, restart on every change of state.
    always_comb begin
        tmr_en  = (st == ST_WAKE_SHORT) || (st == ST_WAKE_PLL) || (st == ST_RESET_LOCK);
        tmr_clr = (st_nx != st);
        unique case (st)
            ST_WAKE_SHORT: tmr_target = T_SHORT;
            ST_WAKE_PLL:   tmr_target = T_PLL;
            default:       tmr_target = T_LOCK;
        endcase
    end

    // State, resume and plain-idle registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_RESET_LOCK;
            resume    <= 1'b0;
            idle_wait <= 1'b0;
        end else begin
            st        <= st_nx;
            resume    <= res_nx;
            idle_wait <= wait_nx;
        end
    end

    // Resume is one cycle wide (R10).
    p_one_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);
    // A pending interrupt keeps the block in run mode and resumes it (R8).
    p_pending_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && idle_stb && irq) |=> (st == ST_RUN && resume));
    // Shallow mode is entered only from an idle strobe (R7).
    p_sleep_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHALLOW && $past(st) != ST_SHALLOW) |-> $past(idle_stb));
endmodule

// File: rtl/pwr_clk_seq.sv
// Power-down mode clock sequencer, top level.
// What it does: turns the mode state into the clock, multiplier and bus
// enables, and joins the state machine, the wake timer and the
// peripheral-rate divider.
// What it assumes: all inputs are synchronous to clk_ref, which never stops.
module pwr_clk_seq
    import pwr_seq_pkg::*;
#(
    parameter int LOCK_CYCLES = 100,
    parameter int SHORT_WAKE  = 6,
    parameter int PLL_SETTLE  = 500
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic mode_stopall,
    input  logic mode_deep,
    input  logic rate_half,
    input  logic idle_stb,
    input  logic irq,
    output logic core_clk_en,
    output logic periph_clk_en,
    output logic pll_run,
    output logic pbus_en,
    output logic ctx_lost,
    output logic resume
);
    localparam int MAX_WAIT = (LOCK_CYCLES > PLL_SETTLE) ? LOCK_CYCLES : PLL_SETTLE;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    pwr_state_e       st;
    logic             tmr_clr;
    logic             tmr_en;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_target;

    pwr_mode_fsm #(
        .LOCK_CYCLES(LOCK_CYCLES),
        .SHORT_WAKE (SHORT_WAKE),
        .PLL_SETTLE (PLL_SETTLE),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .idle_stb    (idle_stb),
        .irq         (irq),
        .mode_stopall(mode_stopall),
        .mode_deep   (mode_deep),
        .tmr_done    (tmr_done),
        .st          (st),
        .tmr_clr     (tmr_clr),
        .tmr_en      (tmr_en),
        .tmr_target  (tmr_target),
        .resume      (resume)
    );

    pwr_wake_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .count_en(tmr_en),
        .target  (tmr_target),
        .done    (tmr_done)
    );

    pwr_pclk_div u_div (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .run      (core_clk_en),
        .rate_half(rate_half),
        .periph_en(periph_clk_en)
    );

    // Decode the enables from the mode state.
    always_comb begin
        core_clk_en = (st == ST_RUN);
        pbus_en     = (st == ST_RUN);
        pll_run     = (st != ST_DEEP);
        ctx_lost    = (st == ST_DEEP) || (st == ST_WAKE_PLL);
    end

    // Deep sleep gates every clock and the bus (R3).
    p_deep_all_off_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ctx_lost |-> (!core_clk_en && !periph_clk_en && !pbus_en));
    // The multiplier runs before the core clock comes back (R5).
    p_pll_first_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(core_clk_en) |-> $past(pll_run));
    // Resume arrives together with the restored clock (R4).
    p_resume_with_clk_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        resume |-> core_clk_en);
    // Any gated state other than deep keeps the multiplier on (R2).
    p_shallow_pll_on_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!core_clk_en && !ctx_lost) |-> pll_run);
endmodule

// File: tb/sim_pwr_clk_seq.sv
module sim_pwr_clk_seq;
    localparam int LOCK   = 100;
    localparam int SHORTW = 6;
    localparam int SETTLE = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_stopall = 1'b0, mode_deep = 1'b0, rate_half = 1'b0;
    logic idle_stb = 1'b0, irq = 1'b0;
    logic core_clk_en, periph_clk_en, pll_run, pbus_en, ctx_lost, resume;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_clk_seq #(.LOCK_CYCLES(LOCK), .SHORT_WAKE(SHORTW), .PLL_SETTLE(SETTLE)) u0 (
        .clk_ref(clk), .rst_n(rst_n), .mode_stopall(mode_stopall),
        .mode_deep(mode_deep), .rate_half(rate_half), .idle_stb(idle_stb),
        .irq(irq), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .pll_run(pll_run), .pbus_en(pbus_en), .ctx_lost(ctx_lost), .resume(resume)
    );

    // Behavioural reference: mode number, absolute wake cycle, run-length counter.
    // modes: 0 run, 1 shallow, 2 deep, 3 short wake, 4 pll wake, 5 lock wait
    int  cyc = 0;
    int  m_mode = 5;
    int  wake_at = LOCK;
    bit  m_res = 1'b0;
    bit  plain_wait = 1'b0;
    int  run_len = 0;

    always @(posedge clk) begin
        int  nmode;
        bit  nres;
        nmode = m_mode;
        nres  = 1'b0;
        if (!rst_n) begin
            nmode = 5; wake_at = cyc + 1 + LOCK; plain_wait = 1'b0;
        end else begin
            case (m_mode)
                0: begin
                    if (idle_stb) begin
                        plain_wait = 1'b0;
                        if (irq) nres = 1'b1;
                        else if (mode_deep) nmode = 2;
                        else if (mode_stopall) nmode = 1;
                        else plain_wait = 1'b1;
                    end else if (plain_wait && irq) begin
                        nres = 1'b1; plain_wait = 1'b0;
                    end
                end
                1: if (irq) begin nmode = 3; wake_at = cyc + SHORTW; end
                2: if (irq) begin nmode = 4; wake_at = cyc + SETTLE; end
                3, 4: if (cyc + 1 == wake_at) begin nmode = 0; nres = 1'b1; end
                default: if (cyc + 1 == wake_at) nmode = 0;
            endcase
        end
        run_len = (nmode == 0 && m_mode == 0) ? run_len + 1 : 0;
        m_mode = nmode;
        m_res  = nres;
        cyc++;
    end

    task automatic cmp(string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, name, act, exp, cyc);
        end
    endtask

    // Compare every output with the reference on each falling edge.
    always @(negedge clk) begin
        if (!done) begin
            cmp("core_clk_en",   core_clk_en,   m_mode == 0);
            cmp("periph_clk_en", periph_clk_en, (m_mode == 0) && (!rate_half || (run_len % 2 == 0)));
            cmp("pll_run",       pll_run,       m_mode != 2);
            cmp("pbus_en",       pbus_en,       m_mode == 0);
            cmp("ctx_lost",      ctx_lost,      (m_mode == 2) || (m_mode == 4));
            cmp("resume",        resume,        m_res);
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_idle();
        idle_stb = 1'b1; step(1); idle_stb = 1'b0;
    endtask

    task automatic pulse_irq();
        irq = 1'b1; step(1); irq = 1'b0;
    endtask

    initial begin
        // R1: reset state and lock wait
        tag = "R1";
        step(4);
        rst_n = 1'b1;
        step(LOCK + 4);
        // R6: peripheral rate at full and half rate
        tag = "R6";
        step(6); rate_half = 1'b1; step(9); rate_half = 1'b0; step(3);
        // R7: interrupt in run mode with nothing outstanding
        tag = "R7";
        pulse_irq(); step(4);
        // R9: plain idle keeps clocks, resume after the later interrupt
        tag = "R9";
        pulse_idle(); step(5); pulse_irq(); step(4);
        // R8: interrupt already pending at the idle strobe
        tag = "R8";
        mode_stopall = 1'b1; irq = 1'b1; pulse_idle(); irq = 1'b0; step(4);
        // R2: shallow entry, then R7: idle strobes during sleep are ignored
        tag = "R2";
        rate_half = 1'b1;
        pulse_idle(); step(6);
        tag = "R7";
        pulse_idle(); step(3);
        // R4: shallow exit timing
        tag = "R4";
        pulse_irq(); step(12);
        // R3: deep entry with both mode bits set
        tag = "R3";
        mode_deep = 1'b1;
        pulse_idle(); step(10);
        tag = "R7";
        pulse_idle(); step(3);
        // R5: deep exit after the settle wait
        tag = "R5";
        pulse_irq(); step(SETTLE + 8);
        // R3 and R5 again with the stop-all bit clear
        tag = "R3";
        mode_stopall = 1'b0; rate_half = 1'b0;
        pulse_idle(); step(4);
        tag = "R5";
        irq = 1'b1; step(3); irq = 1'b0; step(SETTLE + 6);
        // R10: one resume per exit, another plain idle
        tag = "R10";
        mode_deep = 1'b0;
        pulse_idle(); step(2); irq = 1'b1; step(4); irq = 1'b0; step(4);
        // R1: a second reset in the middle of run mode
        tag = "R1";
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(LOCK + 3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog %s: actual timeout expected completion", tag);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule